// File: doc/BRIEF.md
# Maskable Interrupt Gate with Boundary Acceptance

This block sits beside a simple in-order CPU core and decides when a maskable interrupt may be taken. It holds one global enable flag and one pending bit per interrupt source. Sources raise single-cycle pulses that are already synchronous to the core clock. Each pulse latches the matching pending bit. Software can clear pending bits through a write port. At every instruction boundary, which the core marks with a one-cycle strobe, the block decides whether to start the interrupt sequence. When it does, it names the winning source.

The core also reports writes to the enable flag and says which kind of instruction made each one. A write from a return-from-interrupt instruction counts in the decision at that instruction's own boundary. A write from any other flag-writing instruction (set, clear, pop of the flags, load of a control register) counts only from the following boundary. The lowest-numbered pending source always wins. Taking an interrupt drops the enable flag and clears the winner's pending bit.

Top module: `irq_gate_ctrl`

## Requirements
- R1: While reset is held and right after it, the enable flag reads 0, all pending bits read 0 and no accept pulse is produced.
- R2: With the enable flag at 0, a boundary strobe produces no accept pulse, even when pending bits are set.
- R3: A pulse on source input bit k sets pending bit k, and the bit is visible on the pending output one cycle later.
- R4: When an interrupt is accepted, the winner's pending bit reads 0 one cycle later and all other pending bits keep their values. If the same source pulses in that cycle, the bit stays 1.
- R5: A software write to the pending register clears each bit whose data bit is 0. Data bits of 1 leave the matching pending bits unchanged.
- R6: If a source pulse and a software clear hit the same pending bit in one cycle, the bit reads 1 afterwards.
- R7: A flag write with the return flag at 0, given together with a boundary strobe, does not affect that boundary's decision. The new value decides at the next boundary.
- R8: A flag write with the return flag at 1, given together with a boundary strobe, decides that same boundary with the new value.
- R9: An accept pulse appears only in a cycle with the boundary strobe high, an effective enable of 1 and at least one pending bit set. A pulse arriving in that same cycle does not count.
- R10: When several bits are pending, the accept index output gives the lowest set bit position as an unsigned binary number.
- R11: An accept leaves the enable flag at 0 one cycle later. This holds even when a flag write of 1 arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | N_SRC | Per-source request pulses |
| req_clr_we_i | input | 1 | Software write strobe for the pending register |
| req_clr_data_i | input | N_SRC | Write data: 0 clears a bit, 1 keeps it |
| boundary_i | input | 1 | Instruction-boundary strobe |
| flag_wr_i | input | 1 | Enable flag is written this cycle |
| flag_ret_i | input | 1 | The write comes from return-from-interrupt |
| flag_val_i | input | 1 | New enable flag value |
| accept_o | output | 1 | Interrupt sequence starts this cycle |
| accept_idx_o | output | IDX_W | Winning source index |
| req_o | output | N_SRC | Pending bits |
| ien_o | output | 1 | Enable flag |

## Verification
The acceptance decision is tried with both write kinds. Each is tried raising and lowering the flag at a boundary, and the accept result shows whether the old value or the new one was used. Several bits are made pending together (bits 0 and 2, then bit 3 alone, then bits 0 and 7) to separate lowest-index selection from any other order. Clear data with mixed 0 and 1 bits, and same-cycle collisions of a source pulse with a software clear or with an acknowledge, show which update wins. Pending bits arriving away from a boundary, and a reset in the middle of a run, show that nothing is taken outside a strobe.

// File: rtl/irq_gate_pkg.sv
package irq_gate_pkg;
  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/irq_enable_flag.sv
module irq_enable_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_wr_i,
  input  logic flag_ret_i,
  input  logic flag_val_i,
  input  logic accept_i,
  output logic flag_o,
  output logic eff_en_o
);
  logic flag_q, flag_d, flag_ce;

  // return-from-interrupt bypasses the register for the current decision
  always_comb begin
    eff_en_o = (flag_wr_i && flag_ret_i) ? flag_val_i : flag_q;
    flag_ce  = accept_i | flag_wr_i;
    if (accept_i) flag_d = 1'b0;
    else          flag_d = flag_val_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_ce) flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/irq_req_bank.sv
module irq_req_bank #(
  parameter int N_SRC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] set_i,
  input  logic             clr_we_i,
  input  logic [N_SRC-1:0] clr_data_i,
  input  logic             ack_i,
  input  logic [N_SRC-1:0] ack_sel_i,
  output logic [N_SRC-1:0] req_o
);
  logic [N_SRC-1:0] req_q;

  for (genvar k = 0; k < N_SRC; k++) begin : g_bit
    logic bit_d, bit_ce, sw_kill, ack_kill;
    always_comb begin
      sw_kill  = clr_we_i & ~clr_data_i[k];
      ack_kill = ack_i & ack_sel_i[k];
      bit_ce   = set_i[k] | sw_kill | ack_kill;
      bit_d    = set_i[k];  // set dominates both clear sources
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      req_q[k] <= 1'b0;
      else if (bit_ce) req_q[k] <= bit_d;
    end
  end

  assign req_o = req_q;
endmodule

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
  parameter int N_SRC = 8,
  localparam int IDX_W = irq_gate_pkg::idx_width(N_SRC)
) (
  input  logic [N_SRC-1:0] req_i,
  output logic             any_o,
  output logic [N_SRC-1:0] onehot_o,
  output logic [IDX_W-1:0] idx_o
);
  logic [N_SRC:0] below;
  assign below[0] = 1'b0;

  for (genvar k = 0; k < N_SRC; k++) begin : g_chain
    assign below[k+1]  = below[k] | req_i[k];
    assign onehot_o[k] = req_i[k] & ~below[k];
  end

  assign any_o = below[N_SRC];

  always_comb begin
    idx_o = '0;
    for (int k = 0; k < N_SRC; k++)
      if (onehot_o[k]) idx_o = idx_o | IDX_W'(k);
  end
endmodule

// File: rtl/irq_gate_ctrl.sv
module irq_gate_ctrl #(
  parameter int N_SRC = 8,
  localparam int IDX_W = irq_gate_pkg::idx_width(N_SRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] irq_i,
  input  logic             req_clr_we_i,
  input  logic [N_SRC-1:0] req_clr_data_i,
  input  logic             boundary_i,
  input  logic             flag_wr_i,
  input  logic             flag_ret_i,
  input  logic             flag_val_i,
  output logic             accept_o,
  output logic [IDX_W-1:0] accept_idx_o,
  output logic [N_SRC-1:0] req_o,
  output logic             ien_o
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             eff_en, any_pend;
  logic [N_SRC-1:0] win_1h;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  irq_enable_flag u_flag (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .flag_wr_i  (flag_wr_i),
    .flag_ret_i (flag_ret_i),
    .flag_val_i (flag_val_i),
    .accept_i   (accept_o),
    .flag_o     (ien_o),
    .eff_en_o   (eff_en)
  );

  irq_lowest_pick #(.N_SRC(N_SRC)) u_pick (
    .req_i    (req_o),
    .any_o    (any_pend),
    .onehot_o (win_1h),
    .idx_o    (accept_idx_o)
  );

  irq_req_bank #(.N_SRC(N_SRC)) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .set_i      (irq_i),
    .clr_we_i   (req_clr_we_i),
    .clr_data_i (req_clr_data_i),
    .ack_i      (accept_o),
    .ack_sel_i  (win_1h),
    .req_o      (req_o)
  );

  assign accept_o = boundary_i & eff_en & any_pend;
endmodule

// File: rtl/irq_gate_ctrl_chk.sv
module irq_gate_ctrl_chk #(
  parameter int N_SRC = 8,
  localparam int IDX_W = irq_gate_pkg::idx_width(N_SRC)
) (
  input logic             clk,
  input logic             rst_n_int,
  input logic [N_SRC-1:0] irq_i,
  input logic             req_clr_we_i,
  input logic [N_SRC-1:0] req_clr_data_i,
  input logic             boundary_i,
  input logic             flag_wr_i,
  input logic             flag_ret_i,
  input logic             flag_val_i,
  input logic             accept_o,
  input logic [IDX_W-1:0] accept_idx_o,
  input logic [N_SRC-1:0] req_o,
  input logic             ien_o
);
  assert_blocked_R2: assert property (@(posedge clk) disable iff (!rst_n_int)
    (boundary_i && !ien_o && !(flag_wr_i && flag_ret_i && flag_val_i)) |-> !accept_o);

  assert_pulse_latches_R3: assert property (@(posedge clk) disable iff (!rst_n_int)
    (|irq_i) |=> ((req_o & $past(irq_i)) == $past(irq_i)));

  assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n_int)
    (accept_o && !irq_i[accept_idx_o]) |=> !req_o[$past(accept_idx_o)]);

  assert_write_one_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n_int)
    (req_clr_we_i && !accept_o) |=>
      ((req_o & $past(req_clr_data_i)) == (($past(req_o) | $past(irq_i)) & $past(req_clr_data_i))));

  assert_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n_int)
    accept_o |-> (boundary_i && (|req_o)));

  assert_winner_lowest_R10: assert property (@(posedge clk) disable iff (!rst_n_int)
    accept_o |-> (req_o[accept_idx_o] &&
                  ((req_o & ((N_SRC'(1) << accept_idx_o) - N_SRC'(1))) == '0)));

  assert_flag_drop_R11: assert property (@(posedge clk) disable iff (!rst_n_int)
    accept_o |=> !ien_o);
endmodule

bind irq_gate_ctrl irq_gate_ctrl_chk #(.N_SRC(N_SRC)) u_chk (
  .clk            (clk),
  .rst_n_int      (rst_n_int),
  .irq_i          (irq_i),
  .req_clr_we_i   (req_clr_we_i),
  .req_clr_data_i (req_clr_data_i),
  .boundary_i     (boundary_i),
  .flag_wr_i      (flag_wr_i),
  .flag_ret_i     (flag_ret_i),
  .flag_val_i     (flag_val_i),
  .accept_o       (accept_o),
  .accept_idx_o   (accept_idx_o),
  .req_o          (req_o),
  .ien_o          (ien_o)
);

// File: tb/irq_gate_ctrl_test.sv
module irq_gate_ctrl_test;
  localparam int N = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [N-1:0] irq, clr_dat;
  logic         clr_we, bnd, fwr, fret, fval;
  logic         acc, ien;
  logic [2:0]   idx;
  logic [N-1:0] req;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_gate_ctrl #(.N_SRC(N)) uut (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .req_clr_we_i(clr_we),
    .req_clr_data_i(clr_dat), .boundary_i(bnd), .flag_wr_i(fwr),
    .flag_ret_i(fret), .flag_val_i(fval), .accept_o(acc),
    .accept_idx_o(idx), .req_o(req), .ien_o(ien)
  );

  typedef struct packed {
    logic [7:0] irq;
    logic       we;
    logic [7:0] dat;
    logic       bnd;
    logic       fwr;
    logic       fret;
    logic       fval;
    logic       e_acc;
    logic [2:0] e_idx;
    logic [7:0] e_req;
    logic       e_ien;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t TAB [NV] = '{
    '{8'h05,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h05,1'b0}, // 0  R3 latch
    '{8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h05,1'b0}, // 1  R2 blocked
    '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b0,1'b1, 1'b0,3'd0,8'h05,1'b1}, // 2  R7 old value
    '{8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b1,3'd0,8'h04,1'b0}, // 3  R7 R10 R4 R11
    '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b1,1'b1, 1'b1,3'd2,8'h00,1'b0}, // 4  R8 immediate
    '{8'h80,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h80,1'b0}, // 5  R3
    '{8'h00,1'b0,8'h00,1'b0,1'b1,1'b0,1'b1, 1'b0,3'd0,8'h80,1'b1}, // 6  flag write off strobe
    '{8'h01,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h81,1'b1}, // 7  R9 no strobe
    '{8'h00,1'b0,8'h00,1'b1,1'b0,1'b0,1'b0, 1'b1,3'd0,8'h80,1'b0}, // 8  R10 bit0 over bit7
    '{8'h00,1'b1,8'h7F,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h00,1'b0}, // 9  R5 clear bit7
    '{8'h0C,1'b0,8'h00,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h0C,1'b0}, // 10 R3
    '{8'h08,1'b1,8'hF3,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h08,1'b0}, // 11 R6 set beats clear
    '{8'h00,1'b1,8'hFF,1'b0,1'b0,1'b0,1'b0, 1'b0,3'd0,8'h08,1'b0}, // 12 R5 ones keep
    '{8'h08,1'b0,8'h00,1'b1,1'b1,1'b1,1'b1, 1'b1,3'd3,8'h08,1'b0}, // 13 R4 set beats ack
    '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b0,1'b1, 1'b0,3'd0,8'h08,1'b1}, // 14 R7
    '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b0,1'b0, 1'b1,3'd3,8'h00,1'b0}, // 15 R7 old 1 used
    '{8'h10,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0, 1'b0,3'd0,8'h10,1'b0}, // 16 R9 pulse too late
    '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b0,1'b1, 1'b0,3'd0,8'h10,1'b1}, // 17 R7
    '{8'h00,1'b0,8'h00,1'b1,1'b1,1'b1,1'b0, 1'b0,3'd0,8'h10,1'b0}  // 18 R8 new 0 blocks
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    irq = '0; clr_we = 1'b0; clr_dat = '0;
    bnd = 1'b0; fwr = 1'b0; fret = 1'b0; fval = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 flag in reset", int'(ien), 0);
    chk("R1 pending in reset", int'(req), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 flag after reset", int'(ien), 0);
    chk("R1 pending after reset", int'(req), 0);
    chk("R1 accept after reset", int'(acc), 0);

    for (int i = 0; i < NV; i++) begin
      irq = TAB[i].irq; clr_we = TAB[i].we; clr_dat = TAB[i].dat;
      bnd = TAB[i].bnd; fwr = TAB[i].fwr; fret = TAB[i].fret; fval = TAB[i].fval;
      #2;
      chk($sformatf("R9 accept row %0d", i), int'(acc), int'(TAB[i].e_acc));
      if (TAB[i].e_acc)
        chk($sformatf("R10 index row %0d", i), int'(idx), int'(TAB[i].e_idx));
      @(posedge clk);
      #1;
      idle();
      chk($sformatf("R4 pending row %0d", i), int'(req), int'(TAB[i].e_req));
      chk($sformatf("R11 flag row %0d", i), int'(ien), int'(TAB[i].e_ien));
      @(negedge clk);
    end

    // R11: accept overrides a same-cycle immediate write of 1
    fwr = 1'b1; fval = 1'b1; irq = 8'h40;
    @(negedge clk);
    idle();
    bnd = 1'b1; fwr = 1'b1; fret = 1'b1; fval = 1'b1;
    #2;
    chk("R11 accept with write", int'(acc), 1);
    chk("R10 index bit4", int'(idx), 4);
    @(negedge clk);
    idle();
    chk("R11 flag dropped", int'(ien), 0);
    chk("R4 bit4 cleared", int'(req[4]), 0);
    chk("R4 bit6 kept", int'(req[6]), 1);

    // R9: flag 1 and pending, but no strobe for several cycles
    fwr = 1'b1; fval = 1'b1;
    @(negedge clk);
    idle();
    for (int c = 0; c < 3; c++) begin
      #2;
      chk("R9 no strobe", int'(acc), 0);
      @(negedge clk);
    end

    // R1: reset in mid-run wipes state
    irq = 8'h21;
    @(negedge clk);
    idle();
    rst_n = 1'b0;
    #1;
    chk("R1 mid-run flag", int'(ien), 0);
    chk("R1 mid-run pending", int'(req), 0);
    bnd = 1'b1;
    #1;
    chk("R1 mid-run accept", int'(acc), 0);
    idle();
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 after second reset", int'(req), 0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule